// File: doc/BRIEF.md
# SPI Master with Programmable Select-to-Clock Lead

This block is a full-duplex SPI master that serves four slave-select lines. Software sets it up through a small register port. It writes a 16-bit clock divider, a per-line select polarity, the SCK idle level, a 2-bit extra-lead count and a transmit word. A single write to the command register then names the target line and a length of 1 to 32 bits, and the access starts on that write. There is no separate go bit. The received bits collect in a shift register. They are copied to a read register only when the access is over.

The time from select assertion to the first SCK edge is under control. The first edge comes half an SCK period plus one system clock after the select goes active. Zero to three whole SCK periods can be added on top of that. With a large divider, this gives long wake-up gaps for slaves that need their select held for a while before any clock. Each line's polarity bit inverts it at all times. Setting that bit on an idle line therefore holds the line at the level an active-low slave reads as selected. A slave can in this way be kept selected across several accesses, or for an arbitrary time before one.

The register port has no back-pressure. Every write is taken on the edge that samples it, and reads are combinational. A command written while an access is running is not queued: it is dropped and a sticky flag records it.

Top module: `spi_lead_master`

Register map (address: contents):
- 0, DIV: bits [15:0] divider D. Half an SCK period is H = D+1 system clocks. A write of 0xFFFF is stored as 0xFFFE.
- 1, CFG: bits [3:0] line polarity, one per line. Bit 4 is the SCK idle level. Bits [9:8] are the extra-lead count E.
- 2, TXW: bits [31:0] transmit word. The low N bits are sent, most significant first.
- 3, GO (write only): bits [1:0] target line, bits [12:8] length N-1.
- 4, STAT: bit 0 busy, bit 1 overrun. Writing 1 to bit 1 clears overrun.
- 5, RXW: the received word, right-justified, with zero above the N bits.

## Requirements
- R1: After reset all select lines are high, SCK and MOSI are low, busy is low, and every register reads zero.
- R2: DIV holds all 16 bits as written, except that 0xFFFF is stored and read back as 0xFFFE.
- R3: A GO write while idle starts an access on the sampling edge. busy_o is high and the target line active from the next cycle.
- R4: The first SCK edge follows the GO edge by L = H + 1 + 2·H·E system clocks.
- R5: SCK toggles every H clocks and gives exactly N leading edges. The slave sees the low N bits of TXW, most significant first. MOSI changes only on trailing edges.
- R6: MISO is sampled on each leading edge. RXW shows the new word only when the access ends and keeps its old value while one runs.
- R7: The select line returns inactive, and busy clears, H clocks after the last SCK edge. busy is high for exactly L + 2·N·H clocks.
- R8: A GO write while busy is ignored: target, timing and data stay unchanged. It sets the sticky overrun bit, STAT bit 1, which a write of 1 to that bit clears.
- R9: Line i is ~(active_i) XOR polarity[i]. With polarity 1, an idle line sits low and goes high while it is the target.
- R10: SCK rests at CFG bit 4 whenever no access runs. The leading edge moves SCK away from that level.
- R11: During an access only the target line differs from its idle level. The target does not change until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Write address |
| reg_wdata_i | input | 32 | Write data |
| reg_raddr_i | input | 3 | Read address |
| reg_rdata_o | output | 32 | Read data, combinational |
| busy_o | output | 1 | Access in progress |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| sel_line_o | output | 4 | Slave-select lines after polarity |

## Verification
All timing is measured from the edge that samples the GO write. Outputs are read half a clock after each edge, so busy and the target line are due at the first such sample. The first SCK change is due at sample L+1, and busy falls after exactly L+2·N·H samples. A monitor counts these samples for every access and compares them with items the driver queued from H, E and N. It also checks that the line pattern holds on every busy sample. RXW is read mid-access, where it must hold the previous result, and again after busy falls.

// File: rtl/spi_lead_pkg.sv
`timescale 1ns/1ps
package spi_lead_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_DIV  = 3'd0;
  localparam logic [REG_AW-1:0] A_CFG  = 3'd1;
  localparam logic [REG_AW-1:0] A_TXW  = 3'd2;
  localparam logic [REG_AW-1:0] A_GO   = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT = 3'd4;
  localparam logic [REG_AW-1:0] A_RXW  = 3'd5;

  localparam int CFG_CPOL_BIT = 4;
  localparam int CFG_LEAD_LSB = 8;
  localparam int GO_LEN_LSB   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HI,
    ST_LO,
    ST_TAIL
  } seq_state_e;
endpackage

// File: rtl/spi_lead_regs.sv
`timescale 1ns/1ps
module spi_lead_regs
  import spi_lead_pkg::*;
#(
  parameter int DW   = 32,
  parameter int DIVW = 16,
  parameter int NSEL = 4,
  parameter int SELW = 2,
  parameter int LENW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] waddr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [REG_AW-1:0] raddr_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic [DW-1:0]     rx_word_i,
  output logic [DIVW-1:0]   div_o,
  output logic [NSEL-1:0]   pol_o,
  output logic              cpol_o,
  output logic [1:0]        lead_o,
  output logic [DW-1:0]     tx_o,
  output logic              start_o,
  output logic [SELW-1:0]   sel_o,
  output logic [LENW-1:0]   lenm1_o
);
  localparam logic [DIVW-1:0] DIV_MAX = {{(DIVW-1){1'b1}}, 1'b0};

  logic [DIVW-1:0] div_q;
  logic [NSEL-1:0] pol_q;
  logic            cpol_q;
  logic [1:0]      lead_q;
  logic [DW-1:0]   tx_q;
  logic            ovr_q;
  logic            go_wr;

  assign go_wr   = we_i && (waddr_i == A_GO);
  assign start_o = go_wr && !busy_i;
  assign sel_o   = wdata_i[SELW-1:0];
  assign lenm1_o = wdata_i[GO_LEN_LSB +: LENW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      pol_q  <= '0;
      cpol_q <= 1'b0;
      lead_q <= 2'b00;
      tx_q   <= '0;
    end else if (we_i) begin
      case (waddr_i)
        A_DIV: div_q <= (wdata_i[DIVW-1:0] == '1) ? DIV_MAX : wdata_i[DIVW-1:0];
        A_CFG: begin
          pol_q  <= wdata_i[NSEL-1:0];
          cpol_q <= wdata_i[CFG_CPOL_BIT];
          lead_q <= wdata_i[CFG_LEAD_LSB +: 2];
        end
        A_TXW: tx_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ovr_q <= 1'b0;
    else if (go_wr && busy_i)
      ovr_q <= 1'b1;
    else if (we_i && (waddr_i == A_STAT) && wdata_i[1])
      ovr_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (raddr_i)
      A_DIV:  rdata_o[DIVW-1:0] = div_q;
      A_CFG: begin
        rdata_o[NSEL-1:0]             = pol_q;
        rdata_o[CFG_CPOL_BIT]         = cpol_q;
        rdata_o[CFG_LEAD_LSB +: 2]    = lead_q;
      end
      A_TXW:  rdata_o = tx_q;
      A_STAT: rdata_o[1:0] = {ovr_q, busy_i};
      A_RXW:  rdata_o = rx_word_i;
      default: rdata_o = '0;
    endcase
  end

  assign div_o  = div_q;
  assign pol_o  = pol_q;
  assign cpol_o = cpol_q;
  assign lead_o = lead_q;
  assign tx_o   = tx_q;

  p_div_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q != '1);

  p_overrun_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_wr && busy_i) |=> ovr_q);
endmodule

// File: rtl/spi_lead_engine.sv
`timescale 1ns/1ps
module spi_lead_engine
  import spi_lead_pkg::*;
#(
  parameter int DW   = 32,
  parameter int DIVW = 16,
  parameter int SELW = 2,
  parameter int LENW = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [LENW-1:0] lenm1_i,
  input  logic [DW-1:0]   tx_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [1:0]      lead_i,
  input  logic            miso_i,
  output logic            busy_o,
  output logic            sck_ph_o,
  output logic            mosi_o,
  output logic [SELW-1:0] sel_q_o,
  output logic [DW-1:0]   rx_word_o
);
  localparam int CW = DIVW + 4;

  seq_state_e      st_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   half_q;
  logic [LENW-1:0] left_q;
  logic [DW-1:0]   tx_sh_q;
  logic [DW-1:0]   rx_sh_q;
  logic [DW-1:0]   rx_word_q;
  logic [SELW-1:0] sel_q;
  logic            sck_ph_q;

  logic [CW-1:0]   half_w;
  logic [CW-1:0]   lead_m1_w;
  logic [LENW-1:0] sh_amt_w;
  logic            tick_w;

  assign half_w    = CW'(div_i) + CW'(1);
  assign lead_m1_w = half_w + CW'(lead_i) * (half_w << 1);
  assign sh_amt_w  = LENW'(DW - 1) - lenm1_i;
  assign tick_w    = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      half_q    <= '0;
      left_q    <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      rx_word_q <= '0;
      sel_q     <= '0;
      sck_ph_q  <= 1'b0;
    end else if (start_i) begin
      st_q     <= ST_LEAD;
      cnt_q    <= lead_m1_w;
      half_q   <= half_w;
      left_q   <= lenm1_i;
      tx_sh_q  <= tx_i << sh_amt_w;
      rx_sh_q  <= '0;
      sel_q    <= sel_i;
      sck_ph_q <= 1'b0;
    end else begin
      case (st_q)
        ST_LEAD, ST_LO: begin
          if (tick_w) begin
            sck_ph_q <= 1'b1;
            rx_sh_q  <= {rx_sh_q[DW-2:0], miso_i};
            st_q     <= ST_HI;
            cnt_q    <= half_q - CW'(1);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_HI: begin
          if (tick_w) begin
            sck_ph_q <= 1'b0;
            cnt_q    <= half_q - CW'(1);
            if (left_q == '0) begin
              st_q <= ST_TAIL;
            end else begin
              tx_sh_q <= tx_sh_q << 1;
              left_q  <= left_q - LENW'(1);
              st_q    <= ST_LO;
            end
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_TAIL: begin
          if (tick_w) begin
            st_q      <= ST_IDLE;
            rx_word_q <= rx_sh_q;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign sck_ph_o  = sck_ph_q;
  assign mosi_o    = tx_sh_q[DW-1];
  assign sel_q_o   = sel_q;
  assign rx_word_o = rx_word_q;

  p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);

  p_lead_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEAD) |-> !sck_ph_q);

  p_rx_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((st_q == ST_TAIL) && tick_w) |=> $stable(rx_word_q));

  p_sck_rest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sck_ph_q);

  p_sel_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(sel_q)));
endmodule

// File: rtl/spi_lead_seldrv.sv
`timescale 1ns/1ps
module spi_lead_seldrv #(
  parameter int NSEL = 4,
  parameter int SELW = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [NSEL-1:0] pol_i,
  output logic [NSEL-1:0] line_o
);
  logic [NSEL-1:0] hit_w;

  for (genvar g = 0; g < NSEL; g++) begin : g_line
    assign hit_w[g]  = active_i && (sel_i == SELW'(g));
    assign line_o[g] = ~hit_w[g] ^ pol_i[g];
  end

  p_single_target_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(line_o ^ ~pol_i) == (active_i ? 1 : 0));
endmodule

// File: rtl/spi_lead_master.sv
`timescale 1ns/1ps
module spi_lead_master
  import spi_lead_pkg::*;
#(
  parameter int DW   = 32,
  parameter int DIVW = 16,
  parameter int NSEL = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_waddr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [REG_AW-1:0] reg_raddr_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NSEL-1:0]   sel_line_o
);
  localparam int SELW = (NSEL > 1) ? $clog2(NSEL) : 1;
  localparam int LENW = $clog2(DW);

  logic [DIVW-1:0] div_w;
  logic [NSEL-1:0] pol_w;
  logic            cpol_w;
  logic [1:0]      lead_w;
  logic [DW-1:0]   tx_w;
  logic            start_w;
  logic [SELW-1:0] sel_w;
  logic [LENW-1:0] lenm1_w;
  logic            busy_w;
  logic            sck_ph_w;
  logic [SELW-1:0] sel_q_w;
  logic [DW-1:0]   rx_word_w;

  spi_lead_regs #(
    .DW(DW), .DIVW(DIVW), .NSEL(NSEL), .SELW(SELW), .LENW(LENW)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .waddr_i   (reg_waddr_i),
    .wdata_i   (reg_wdata_i),
    .raddr_i   (reg_raddr_i),
    .rdata_o   (reg_rdata_o),
    .busy_i    (busy_w),
    .rx_word_i (rx_word_w),
    .div_o     (div_w),
    .pol_o     (pol_w),
    .cpol_o    (cpol_w),
    .lead_o    (lead_w),
    .tx_o      (tx_w),
    .start_o   (start_w),
    .sel_o     (sel_w),
    .lenm1_o   (lenm1_w)
  );

  spi_lead_engine #(
    .DW(DW), .DIVW(DIVW), .SELW(SELW), .LENW(LENW)
  ) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_w),
    .sel_i     (sel_w),
    .lenm1_i   (lenm1_w),
    .tx_i      (tx_w),
    .div_i     (div_w),
    .lead_i    (lead_w),
    .miso_i    (miso_i),
    .busy_o    (busy_w),
    .sck_ph_o  (sck_ph_w),
    .mosi_o    (mosi_o),
    .sel_q_o   (sel_q_w),
    .rx_word_o (rx_word_w)
  );

  spi_lead_seldrv #(
    .NSEL(NSEL), .SELW(SELW)
  ) u_seldrv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (busy_w),
    .sel_i    (sel_q_w),
    .pol_i    (pol_w),
    .line_o   (sel_line_o)
  );

  assign busy_o = busy_w;
  assign sck_o  = cpol_w ^ sck_ph_w;
endmodule

// File: tb/spi_lead_master_tb_top.sv
`timescale 1ns/1ps
module spi_lead_master_tb_top;
  import spi_lead_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  raddr = '0;
  logic [31:0] rdata;
  logic        busy_o;
  logic        sck_o;
  logic        mosi_o;
  logic        miso;
  logic [3:0]  sel_line;

  always #5 clk = ~clk;

  spi_lead_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_waddr_i(waddr),
    .reg_wdata_i(wdata), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .busy_o(busy_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso),
    .sel_line_o(sel_line)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // slave model
  logic [31:0] slv_pat = '0;
  int          slv_len = 1;
  logic [31:0] slv_sr = '0;
  logic [31:0] slv_cap = '0;
  logic        cur_cpol = 1'b0;
  logic        sck_last = 1'b0;
  event        slv_load;
  assign miso = slv_sr[31];

  initial begin
    forever begin
      @(sck_o or slv_load);
      if (sck_o !== sck_last) begin
        if (busy_o) begin
          if (sck_o != cur_cpol) slv_cap = {slv_cap[30:0], mosi_o};
          else slv_sr = slv_sr << 1;
        end
        sck_last = sck_o;
      end else begin
        slv_sr  = slv_pat << (32 - slv_len);
        slv_cap = '0;
      end
    end
  end

  // scoreboard
  typedef struct {
    int          lead;
    int          total;
    int          len;
    logic [31:0] mosi;
    int          sel;
    logic [3:0]  pol;
    logic        cpol;
  } exp_t;
  exp_t sb_q[$];

  initial begin
    exp_t cur;
    bit   in_x = 0;
    int   c = 0, first = 0, edges = 0;
    bit   line_bad = 0;
    logic prev = 0;
    logic [3:0] expl;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      if (busy_o && !in_x) begin
        if (sb_q.size() == 0) begin
          chk(0, "R3 unexpected access", 1, 0);
          cur = '{0, 0, 1, 0, 0, 4'h0, 1'b0};
        end else cur = sb_q.pop_front();
        in_x = 1; c = 0; first = 0; edges = 0; line_bad = 0; prev = cur.cpol;
      end
      if (busy_o) begin
        c++;
        if (sck_o != prev && sck_o != cur.cpol) begin
          edges++;
          if (first == 0) first = c;
        end
        prev = sck_o;
        expl = ~cur.pol;
        expl[cur.sel] = cur.pol[cur.sel];
        if (sel_line !== expl) line_bad = 1;
      end else if (in_x) begin
        in_x = 0;
        chk(c == cur.total, "R7 busy length", c, cur.total);
        chk(first == cur.lead + 1, "R4 first edge", first, cur.lead + 1);
        chk(edges == cur.len, "R5 edge count", edges, cur.len);
        chk(slv_cap == cur.mosi, "R5 mosi word", slv_cap, cur.mosi);
        chk(!line_bad, "R11 select pattern", line_bad, 0);
        chk(sel_line == ~cur.pol, "R7 line released", sel_line, ~cur.pol);
        chk(sck_o == cur.cpol, "R10 sck rest", sck_o, cur.cpol);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    raddr = a;
    #1 d = rdata;
  endtask

  logic [31:0] last_rx = '0;

  // mode: 0 plain, 1 read RXW mid-access, 2 GO write mid-access
  task automatic xfer(input int sel, input int len, input logic [31:0] tx,
                      input logic [31:0] pat, input int div, input int dd,
                      input logic cpol, input logic [3:0] pol, input int mode);
    exp_t e;
    int h;
    logic [31:0] mask, v;
    mask = 32'((64'd1 << len) - 1);
    h = div + 1;
    wr(A_DIV, div);
    wr(A_CFG, {22'b0, dd[1:0], 3'b0, cpol, pol});
    e.lead = h + 1 + 2 * h * dd;
    e.total = e.lead + 2 * len * h;
    e.len = len; e.mosi = tx & mask; e.sel = sel; e.pol = pol; e.cpol = cpol;
    sb_q.push_back(e);
    slv_pat = pat; slv_len = len; cur_cpol = cpol;
    -> slv_load;
    wr(A_TXW, tx);
    wr(A_GO, ((len - 1) << 8) | sel);
    chk(busy_o == 1'b1, "R3 busy after go", busy_o, 1);
    if (mode == 1) begin
      repeat (5) @(negedge clk);
      rd(A_RXW, v);
      chk(v == last_rx, "R6 rx hold", v, last_rx);
    end else if (mode == 2) begin
      repeat (5) @(negedge clk);
      wr(A_GO, ((5 - 1) << 8) | ((sel + 1) % 4));
    end
    while (busy_o) @(negedge clk);
    rd(A_RXW, v);
    chk(v == (pat & mask), "R6 rx word", v, pat & mask);
    last_rx = v;
    if (mode == 2) begin
      rd(A_STAT, v);
      chk(v == 32'h2, "R8 overrun set", v, 2);
      wr(A_STAT, 32'h2);
      rd(A_STAT, v);
      chk(v == 32'h0, "R8 overrun cleared", v, 0);
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sel_line == 4'hF, "R1 lines", sel_line, 4'hF);
    chk(sck_o == 1'b0, "R1 sck", sck_o, 0);
    chk(mosi_o == 1'b0, "R1 mosi", mosi_o, 0);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R1 register zero", v, 0);
    end
    // R2 divider clamp
    wr(A_DIV, 32'h0000_FFFF);
    rd(A_DIV, v);
    chk(v == 32'hFFFE, "R2 clamp", v, 32'hFFFE);
    wr(A_DIV, 32'h0000_1234);
    rd(A_DIV, v);
    chk(v == 32'h1234, "R2 plain", v, 32'h1234);

    xfer(0, 8, 32'h0000_00A5, 32'h0000_003C, 1, 0, 1'b0, 4'h0, 0);
    xfer(1, 32, 32'hDEAD_BEEF, 32'h1234_5678, 2, 3, 1'b0, 4'h0, 1);

    // R10 idle level follows polarity
    wr(A_CFG, 32'h10);
    @(negedge clk);
    chk(sck_o == 1'b1, "R10 idle high", sck_o, 1);
    xfer(3, 1, 32'h1, 32'h1, 0, 1, 1'b1, 4'h0, 0);

    // R9 inverted line
    wr(A_CFG, 32'h4);
    @(negedge clk);
    chk(sel_line == 4'b1011, "R9 forced low", sel_line, 4'b1011);
    xfer(2, 5, 32'h15, 32'h0A, 3, 2, 1'b0, 4'h4, 0);
    @(negedge clk);
    chk(sel_line == 4'b1011, "R9 back low", sel_line, 4'b1011);

    // R8 ignored command while busy
    xfer(0, 16, 32'h0000_C3A5, 32'h0000_5AF0, 1, 0, 1'b0, 4'h0, 2);
    chk(sb_q.size() == 0, "R8 no extra access", sb_q.size(), 0);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
  end
endmodule